// File: doc/BRIEF.md
# Split-Transaction Memory Bus Controller

This block serves a shared processor–memory bus on which a transaction does not hold the bus while memory works. A requester presents an operation (read or write), an address, write data and a transaction tag on the request port. When the controller takes the request, that cycle is the address tenure: the bus is granted for exactly one cycle and then free again. The request moves into one of a small set of fetch slots. Each slot counts down a fixed latency on its own timer. The latency for reads differs from the latency for writes. When a slot's countdown ends, the memory operation takes effect and the result waits in the slot's buffer.

Finished slots then compete for the bus to send their result back. Returning data always wins over a new address tenure in the same cycle. Each return occupies the bus for one cycle. It carries the original tag, so the requester can pair responses with requests even when they arrive in a different order. A new address tenure can overlap the fetch of earlier requests. Because slots finish on their own schedules and the lowest finished slot returns first, responses can come back in a different order from the requests.

Each slot runs a state machine with three states. FREE moves to FETCH on allocation. FETCH moves to DONE when the countdown reaches its last cycle. DONE moves back to FREE when the slot is picked to return. The bus runs a second state machine with two states. OPEN, in which address tenures are allowed, moves to RETURN whenever some slot is DONE at a clock edge. RETURN, in which the response port is driven, moves back to OPEN when no slot is DONE.

Top module: `stb_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `bus_gnt_ret` is 0, and all storage words read as zero.
- R2: `bus_gnt_addr` is high in exactly those cycles where `req_valid` and `req_ready` are both high; each such cycle takes one request, so an address tenure lasts one cycle.
- R3: A read taken at clock edge E finishes its fetch at edge E+RD_LAT. It returns the storage word as it stood before that edge. Writes that finish at the same edge are not visible to it. With no contention, its response is visible in the cycle after edge E+RD_LAT+1.
- R4: A write taken at edge E updates storage at edge E+WR_LAT. Its response has `rsp_write`=1 and echoes the written data in `rsp_data`. With no contention, the response is visible in the cycle after edge E+WR_LAT+1.
- R5: Every response carries in `rsp_id` the tag of a request that is outstanding and whose fetch has completed; each request is answered exactly once.
- R6: While a response is on the bus (`rsp_valid`=1, `bus_gnt_ret`=1), `req_ready` is 0, so the two grants are never high together and data return takes priority over a new address tenure.
- R7: At most NSLOT requests are outstanding at a time. A request counts as outstanding from its acceptance until its response appears. When NSLOT are outstanding, `req_ready` is 0; otherwise it is 1 unless R6 applies.
- R8: Each response occupies the bus for one cycle. `rsp_valid` is 1 in a cycle exactly when some accepted request finished its fetch at an earlier edge and has not yet been answered.
- R9: Responses may leave in a different order from requests: a write taken one cycle after a read is answered before that read when WR_LAT < RD_LAT.
- R10: Fetch countdowns run independently and overlap. A read and a write to the same address that finish at the same edge give the read the old value, and a later read sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take an address tenure this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for a write |
| req_id | input | ID_W | Transaction tag |
| bus_gnt_addr | output | 1 | Bus granted to an address tenure this cycle |
| bus_gnt_ret | output | 1 | Bus held by a data return this cycle |
| rsp_valid | output | 1 | Response on the bus |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_id | output | ID_W | Tag of the answered request |
| rsp_data | output | DATA_W | Read data, or the written data for a write |

## Verification
The bench builds the block with NSLOT=4, RD_LAT=6, WR_LAT=2, a 16-word store and 3-bit tags. The small store makes random reads and writes collide on addresses often. The read/write latency gap of four cycles lets a write overtake a read, and it also lets a directed case land a write and a read on the same completion edge. Four slots against six-cycle reads let back-to-back requests fill the controller. That brings the full condition and a run of consecutive returns within reach, and a fifth request must wait out every one of those returns.

// File: rtl/stb_pkg.sv
package stb_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_FETCH = 2'd1,
        SLOT_DONE  = 2'd2
    } slot_state_e;

    typedef enum logic {
        BUS_OPEN   = 1'b0,
        BUS_RETURN = 1'b1
    } bus_state_e;

endpackage

// File: rtl/stb_lowest.sv
module stb_lowest #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] onehot_o,
    output logic         any_o
);

    always_comb begin
        onehot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/stb_store.sv
module stb_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] words_o [2**ADDR_W]
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign words_o = mem_q;

endmodule

// File: rtl/stb_slot.sv
module stb_slot
    import stb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int ID_W   = 3,
    parameter int RD_LAT = 6,
    parameter int WR_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              op_wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [DATA_W-1:0] mem_word_i,
    input  logic              pick_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              wr_commit_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] word_o,
    output logic [ID_W-1:0]   id_o
);

    localparam int LAT_MAX = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);
    localparam logic [CNT_W-1:0] RD_CNT  = CNT_W'(RD_LAT);
    localparam logic [CNT_W-1:0] WR_CNT  = CNT_W'(WR_LAT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    slot_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] word_q;
    logic [ID_W-1:0]   id_q;
    logic              last;

    assign last = (cnt_q == CNT_ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (alloc_i) state_d = SLOT_FETCH;
            SLOT_FETCH: if (last)    state_d = SLOT_DONE;
            SLOT_DONE:  if (pick_i)  state_d = SLOT_FREE;
            default:                 state_d = SLOT_FREE;
        endcase
    end

    // payload, countdown and fetch buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            word_q <= '0;
            id_q   <= '0;
        end else if (state_q == SLOT_FREE && alloc_i) begin
            cnt_q  <= op_wr_i ? WR_CNT : RD_CNT;
            wr_q   <= op_wr_i;
            addr_q <= addr_i;
            word_q <= wdata_i;
            id_q   <= id_i;
        end else if (state_q == SLOT_FETCH) begin
            cnt_q <= cnt_q - CNT_ONE;
            if (last && !wr_q) begin
                word_q <= mem_word_i;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o      = 1'b0;
        done_o      = 1'b0;
        wr_commit_o = 1'b0;
        unique case (state_q)
            SLOT_FREE:  ;
            SLOT_FETCH: begin
                busy_o      = 1'b1;
                wr_commit_o = last && wr_q;
            end
            SLOT_DONE: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign wr_o   = wr_q;
    assign addr_o = addr_q;
    assign word_o = word_q;
    assign id_o   = id_q;

endmodule

// File: rtl/stb_ctrl.sv
module stb_ctrl
    import stb_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int ID_W   = 3,
    parameter int RD_LAT = 6,
    parameter int WR_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ID_W-1:0]   req_id,
    output logic              bus_gnt_addr,
    output logic              bus_gnt_ret,
    output logic              rsp_valid,
    output logic              rsp_write,
    output logic [ID_W-1:0]   rsp_id,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [NSLOT-1:0]  slot_busy, slot_done, slot_commit, slot_wr;
    logic [NSLOT-1:0]  alloc_oh, pick_oh, alloc_vec;
    logic              free_any, ret_any, accept;
    logic [ADDR_W-1:0] slot_addr [NSLOT];
    logic [DATA_W-1:0] slot_word [NSLOT];
    logic [ID_W-1:0]   slot_id   [NSLOT];
    logic [DATA_W-1:0] mem_words [DEPTH];

    logic              st_we;
    logic [ADDR_W-1:0] st_waddr;
    logic [DATA_W-1:0] st_wdata;

    logic              sel_wr;
    logic [ID_W-1:0]   sel_id;
    logic [DATA_W-1:0] sel_word;

    bus_state_e        bus_q, bus_d;

    // free slot choice for new address tenures, finished slot choice for returns
    stb_lowest #(.N(NSLOT)) u_free_pick (
        .req_i    (~slot_busy),
        .onehot_o (alloc_oh),
        .any_o    (free_any)
    );

    stb_lowest #(.N(NSLOT)) u_ret_pick (
        .req_i    (slot_done),
        .onehot_o (pick_oh),
        .any_o    (ret_any)
    );

    assign accept    = req_valid && req_ready;
    assign alloc_vec = accept ? alloc_oh : '0;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        stb_slot #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .ID_W   (ID_W),
            .RD_LAT (RD_LAT),
            .WR_LAT (WR_LAT)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (alloc_vec[g]),
            .op_wr_i     (req_write),
            .addr_i      (req_addr),
            .wdata_i     (req_wdata),
            .id_i        (req_id),
            .mem_word_i  (mem_words[slot_addr[g]]),
            .pick_i      (pick_oh[g]),
            .busy_o      (slot_busy[g]),
            .done_o      (slot_done[g]),
            .wr_commit_o (slot_commit[g]),
            .wr_o        (slot_wr[g]),
            .addr_o      (slot_addr[g]),
            .word_o      (slot_word[g]),
            .id_o        (slot_id[g])
        );
    end

    // at most one write finishes per edge: merge the commit ports
    always_comb begin
        st_we    = 1'b0;
        st_waddr = '0;
        st_wdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot_commit[i]) begin
                st_we    = 1'b1;
                st_waddr = st_waddr | slot_addr[i];
                st_wdata = st_wdata | slot_word[i];
            end
        end
    end

    stb_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (st_we),
        .waddr_i (st_waddr),
        .wdata_i (st_wdata),
        .words_o (mem_words)
    );

    // return mux
    always_comb begin
        sel_wr   = 1'b0;
        sel_id   = '0;
        sel_word = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (pick_oh[i]) begin
                sel_wr   = sel_wr | slot_wr[i];
                sel_id   = sel_id | slot_id[i];
                sel_word = sel_word | slot_word[i];
            end
        end
    end

    // bus state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= BUS_OPEN;
        end else begin
            bus_q <= bus_d;
        end
    end

    // bus transitions: any finished slot claims the next cycle
    always_comb begin
        bus_d = bus_q;
        unique case (bus_q)
            BUS_OPEN:   if (ret_any)  bus_d = BUS_RETURN;
            BUS_RETURN: if (!ret_any) bus_d = BUS_OPEN;
            default:                  bus_d = BUS_OPEN;
        endcase
    end

    // bus outputs
    always_comb begin
        req_ready   = 1'b0;
        bus_gnt_ret = 1'b0;
        unique case (bus_q)
            BUS_OPEN:   req_ready   = free_any;
            BUS_RETURN: bus_gnt_ret = 1'b1;
            default: ;
        endcase
    end

    assign bus_gnt_addr = accept;

    // response port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_write <= 1'b0;
            rsp_id    <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= ret_any;
            if (ret_any) begin
                rsp_write <= sel_wr;
                rsp_id    <= sel_id;
                rsp_data  <= sel_word;
            end
        end
    end

endmodule

// File: rtl/stb_ctrl_chk.sv
module stb_ctrl_chk #(
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             bus_gnt_addr,
    input logic             bus_gnt_ret,
    input logic             rsp_valid,
    input logic [NSLOT-1:0] slot_busy,
    input logic [NSLOT-1:0] slot_done
);

    a_r6_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_gnt_addr && bus_gnt_ret));

    a_r6_return_blocks_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r7_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(slot_busy) == NSLOT) |-> !req_ready);

    a_r7_occupancy_track: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(slot_busy) ==
                   $past($countones(slot_busy)) + int'($past(bus_gnt_addr)) - int'(rsp_valid)));

    a_r8_done_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_done) |=> rsp_valid);

endmodule

bind stb_ctrl stb_ctrl_chk #(.NSLOT(NSLOT)) u_stb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .bus_gnt_addr (bus_gnt_addr),
    .bus_gnt_ret  (bus_gnt_ret),
    .rsp_valid    (rsp_valid),
    .slot_busy    (slot_busy),
    .slot_done    (slot_done)
);

// File: tb/test_stb_ctrl.sv
module test_stb_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT  = 4;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int ID_W   = 3;
    localparam int RD_LAT = 6;
    localparam int WR_LAT = 2;
    localparam int DEPTH  = 2 ** ADDR_W;
    localparam int NID    = 2 ** ID_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic req_ready, bus_gnt_addr, bus_gnt_ret, rsp_valid, rsp_write;
    logic [ID_W-1:0]   rsp_id;
    logic [DATA_W-1:0] rsp_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stb_ctrl #(
        .NSLOT(NSLOT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ID_W(ID_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
    ) i_stb_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_id(req_id),
        .bus_gnt_addr(bus_gnt_addr), .bus_gnt_ret(bus_gnt_ret),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write),
        .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    int it = 0, n_chk = 0, n_bad = 0, outst = 0;
    bit finished = 0;
    logic [DATA_W-1:0] model_mem [DEPTH];
    bit                p_live [NID];
    bit                p_wr   [NID];
    logic [ADDR_W-1:0] p_addr [NID];
    logic [DATA_W-1:0] p_wdata[NID];
    logic [DATA_W-1:0] p_exp  [NID];
    logic [DATA_W-1:0] r_data [NID];
    int                p_done [NID];
    int                r_it   [NID];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, it);
        end
    endtask

    // one clock cycle: observe, compare, then drive
    task automatic step(input bit v, input bit w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input int id, output bit acc);
        bit exp_rv;
        int rid;
        @(negedge clk);
        it++;
        exp_rv = 0;
        for (int k = 0; k < NID; k++)
            if (p_live[k] && p_done[k] <= it - 1) exp_rv = 1;
        for (int k = 0; k < NID; k++)
            if (p_live[k] && p_done[k] == it && !p_wr[k]) p_exp[k] = model_mem[p_addr[k]];
        for (int k = 0; k < NID; k++)
            if (p_live[k] && p_done[k] == it && p_wr[k]) begin
                model_mem[p_addr[k]] = p_wdata[k];
                p_exp[k] = p_wdata[k];
            end
        check("R8 rsp_valid follows finished fetches", 32'(rsp_valid), 32'(exp_rv));
        check("R6 return grant matches response", 32'(bus_gnt_ret), 32'(rsp_valid));
        if (rsp_valid === 1'b1) begin
            rid = int'(rsp_id);
            check("R5 tag outstanding and fetched",
                  32'(p_live[rid] && p_done[rid] <= it - 1), 32'd1);
            if (p_live[rid]) begin
                if (p_wr[rid]) check("R4 write echo data", 32'(rsp_data), 32'(p_exp[rid]));
                else           check("R3 read data", 32'(rsp_data), 32'(p_exp[rid]));
                check("R4 write flag", 32'(rsp_write), 32'(p_wr[rid]));
                r_data[rid] = rsp_data;
                r_it[rid]   = it;
                p_live[rid] = 0;
                outst--;
            end
        end
        check("R7 ready versus occupancy", 32'(req_ready),
              32'((outst < NSLOT) && !(rsp_valid === 1'b1)));
        req_valid = v;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        req_id    = ID_W'(id);
        #1;
        acc = v && (req_ready === 1'b1);
        check("R2 address grant", 32'(bus_gnt_addr), 32'(acc));
        if (acc) begin
            p_live[id]  = 1;
            p_wr[id]    = w;
            p_addr[id]  = a;
            p_wdata[id] = d;
            p_done[id]  = it + 1 + (w ? WR_LAT : RD_LAT);
            outst++;
        end
    endtask

    task automatic idle();
        bit acc;
        step(0, 0, '0, '0, 0, acc);
    endtask

    task automatic issue(input bit w, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input int id, output int at);
        bit acc;
        int tries = 0;
        do begin
            step(1, w, a, d, id, acc);
            tries++;
        end while (!acc && tries < 200);
        at = it;
    endtask

    task automatic drain();
        while (outst > 0) idle();
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int a, b, id;
        bit acc;
        void'($urandom(32'd20240611));
        for (int k = 0; k < DEPTH; k++) model_mem[k] = '0;
        for (int k = 0; k < NID; k++) begin
            p_live[k] = 0; p_done[k] = 0; r_it[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R1 no response after reset", 32'(rsp_valid), 32'd0);
        check("R1 no return grant after reset", 32'(bus_gnt_ret), 32'd0);

        // R1/R3: storage starts at zero, uncontended read latency
        issue(0, 4'd9, '0, 0, a);
        drain();
        check("R1 storage reset value", 32'(r_data[0]), 32'd0);
        check("R3 read latency", 32'(r_it[0] - a), 32'(RD_LAT + 2));

        // R4: uncontended write latency, then read back
        issue(1, 4'd3, 16'hBEEF, 1, a);
        drain();
        check("R4 write latency", 32'(r_it[1] - a), 32'(WR_LAT + 2));
        issue(0, 4'd3, '0, 0, a);
        drain();
        check("R4 write reached storage", 32'(r_data[0]), 32'h0000BEEF);

        // R9: later write overtakes earlier read
        issue(0, 4'd5, '0, 2, a);
        issue(1, 4'd6, 16'h0055, 3, b);
        drain();
        check("R9 write answered before read", 32'(r_it[3] < r_it[2]), 32'd1);

        // R10: read and write to one address finish on the same edge
        issue(1, 4'd7, 16'h1111, 4, a);
        drain();
        issue(0, 4'd7, '0, 5, a);
        for (int k = 0; k < RD_LAT - WR_LAT - 1; k++) idle();
        issue(1, 4'd7, 16'h2222, 6, b);
        check("R10 write lands on read completion edge", 32'(b - a), 32'(RD_LAT - WR_LAT));
        drain();
        check("R10 read sees old value", 32'(r_data[5]), 32'h00001111);
        issue(0, 4'd7, '0, 7, a);
        drain();
        check("R10 later read sees new value", 32'(r_data[7]), 32'h00002222);

        // R6/R7: fill all slots, extra request waits out every return
        issue(0, 4'd1, '0, 0, a);
        for (int k = 1; k < NSLOT; k++) issue(0, 4'(k + 1), '0, k, b);
        issue(0, 4'd8, '0, NSLOT, b);
        check("R6 fifth request waits for full return run", 32'(b - a), 32'(RD_LAT + 2 + NSLOT));
        drain();

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            bit v = ($urandom % 10) < 6;
            bit w = ($urandom % 10) < 4;
            int start = $urandom % NID;
            id = -1;
            for (int k = 0; k < NID; k++)
                if (id < 0 && !p_live[(start + k) % NID]) id = (start + k) % NID;
            if (id < 0) begin v = 0; id = 0; end
            step(v, w, ADDR_W'($urandom), DATA_W'($urandom), id, acc);
        end
        drain();
        check("R8 every request answered", 32'(outst), 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule